// File: doc/BRIEF.md
# Nine-Bit Multiprocessor Serial Port

This block is a full-duplex asynchronous serial port for a multi-drop link. It sends and receives frames in one of two formats. In the short format, a frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. In the long format, a programmable ninth bit sits between the data and the stop bit. On a shared line, a master sets the ninth bit to mark an address byte and clears it to mark a data byte. A slave can then enable the address filter so that only address bytes reach it, and drop the filter once it has been addressed.

Both directions share one timebase that runs at sixteen times the bit rate. That timebase comes from one of two sources. One is an external tick that pulses for one clock at the oversampling rate. The other is a fixed divider from the system clock, giving a bit rate of clk/64, or clk/32 when the rate-doubling input is set.

Transmit data enters through a valid/ready handshake. `tx_ready` is high only while the transmitter is idle, and a frame starts on the cycle where `tx_valid` and `tx_ready` are both high. While a frame is on the line, `tx_ready` is low, so the source must hold its byte. The receive buffer is presented as valid/ready as well. `rx_valid` is the receive-done flag, and a cycle with `rx_ready` high reads the buffer and clears the flag. A consumer that holds `rx_ready` low applies back-pressure. Frames that complete during back-pressure are lost, and the held byte is kept.

Top module: `mp_serial_port`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1, `tx_done` is 0 and `rx_valid` is 0.
- R2: In the short format (`mode_nine`=0), an accepted byte goes out on `txd` as 0, then data bit 0 through data bit 7, then 1. Each bit lasts 16 oversampling ticks. `tx_ready` is 0 from the cycle after acceptance until the frame ends.
- R3: In the long format (`mode_nine`=1), the frame is 0, then data bit 0 through data bit 7, then `tx_bit9` as sampled at acceptance, then 1.
- R4: With `rate_fixed`=1, one bit on the line lasts 64 clocks when `smod`=0 and 32 clocks when `smod`=1. With `rate_fixed`=0, one bit lasts 16 pulses of `ext_tick`.
- R5: `tx_done` goes to 1 in the cycle in which a frame ends. It stays 1 until a cycle with `tx_done_clr`=1.
- R6: In the short format, a received frame sets `rx_valid`, puts the eight data bits on `rx_data` (first bit received at bit 0), and stores the received stop bit, whether 0 or 1, in `rx_bit9`.
- R7: In the long format, `rx_bit9` holds the received ninth bit. The value of the stop bit has no effect on reception.
- R8: In the long format with `filt_en`=1, a frame whose ninth bit is 0 leaves `rx_valid` at 0. A frame whose ninth bit is 1 sets it as usual.
- R9: While `rx_en`=0, nothing on `rxd` sets `rx_valid`, and dropping `rx_en` aborts a frame in progress.
- R10: A low pulse on `rxd` that is over before the middle of the start bit is rejected as a false start, and the receiver then accepts the next real frame.
- R11: Each received bit is decided by a 2-of-3 majority of the 7th, 8th and 9th oversampling ticks of the bit. A glitch that covers one of those samples does not change the bit.
- R12: If `rx_valid` is still 1 when a new frame completes, the new frame is discarded, and `rx_data` and `rx_bit9` keep the buffered values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_nine | input | 1 | 1: long format with ninth bit; 0: short format |
| rate_fixed | input | 1 | 1: timebase from fixed clock divider; 0: from `ext_tick` |
| smod | input | 1 | Doubles the fixed-divider bit rate (clk/32 instead of clk/64) |
| ext_tick | input | 1 | External oversampling pulse, 16 per bit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter idle, can accept a byte |
| tx_data | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth bit to transmit in the long format |
| tx_done | output | 1 | Sticky frame-sent flag |
| tx_done_clr | input | 1 | Clears `tx_done` |
| txd | output | 1 | Serial output, idles high |
| rx_en | input | 1 | Receive enable |
| filt_en | input | 1 | Address filter enable (long format only) |
| rxd | input | 1 | Serial input |
| rx_valid | output | 1 | Receive buffer holds an unread frame |
| rx_ready | input | 1 | Consumer reads the buffer, clearing `rx_valid` |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Received ninth bit (the stop bit in the short format) |

## Verification
The transmitter is driven with bytes of mixed bit patterns in both formats and with both ninth-bit values. This shows whether bit order and the ninth-bit slot are right. An alternating byte sent through the fixed divider, at both rate settings, exposes a wrong division ratio as a wrong width of one data bit. Looping the line back shows that the receiver shares that timebase. The receiver is fed frames with a low stop bit, which separates storing the stop bit in the short format from ignoring it in the long one. It is also fed pairs of frames that differ only in the ninth bit, under the filter, which shows whether the filter uses that bit. Short low pulses, single-sample glitches inside data bits, frames sent while disabled and frames sent during back-pressure each test one of the receiver's rejection paths, and a correct frame follows each one.

// File: rtl/msp_pkg.sv
package msp_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_t;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/msp_baud.sv
module msp_baud #(
  parameter int OVS     = 16,
  parameter int FIX_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_fixed,
  input  logic smod,
  input  logic ext_tick,
  output logic tick
);
  localparam int SLOW = FIX_DIV / OVS;
  localparam int FAST = SLOW / 2;
  localparam int CW   = $clog2(SLOW + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = smod ? CW'(FAST - 1) : CW'(SLOW - 1);
  assign tick = rate_fixed ? (cnt == lim) : ext_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!rate_fixed)      cnt <= '0;
    else if (cnt >= lim)       cnt <= '0;
    else                       cnt <= cnt + CW'(1);
  end

  // R4: divided ticks are never back to back
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rate_fixed && tick |=> (!rate_fixed || !tick));
endmodule

// File: rtl/msp_tx.sv
module msp_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mode_nine,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_bit9,
  output logic          tx_done,
  input  logic          tx_done_clr,
  output logic          txd
);
  localparam int FW  = DW + 3;
  localparam int OCW = $clog2(OVS);
  localparam int BCW = $clog2(FW + 1);

  logic           busy;
  logic [FW-1:0]  shreg;
  logic [OCW-1:0] ocnt;
  logic [BCW-1:0] bcnt;
  logic [BCW-1:0] nbits;
  logic           bit_end;
  logic           frame_end;

  assign nbits     = mode_nine ? BCW'(FW) : BCW'(FW - 1);
  assign bit_end   = busy && tick && (ocnt == OCW'(OVS - 1));
  assign frame_end = bit_end && (bcnt == nbits - BCW'(1));
  assign tx_ready  = !busy;
  assign txd       = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      ocnt  <= '0;
      bcnt  <= '0;
    end else if (tx_valid && !busy) begin
      busy  <= 1'b1;
      shreg <= {1'b1, (mode_nine ? tx_bit9 : 1'b1), tx_data, 1'b0};
      ocnt  <= '0;
      bcnt  <= '0;
    end else if (busy && tick) begin
      if (bit_end) begin
        ocnt  <= '0;
        shreg <= {1'b1, shreg[FW-1:1]};
        if (frame_end) busy <= 1'b0;
        else           bcnt <= bcnt + BCW'(1);
      end else begin
        ocnt <= ocnt + OCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tx_done <= 1'b0;
    else if (frame_end)   tx_done <= 1'b1;
    else if (tx_done_clr) tx_done <= 1'b0;
  end

  // R2: acceptance drives the start bit and drops ready on the next cycle
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready && !txd);
  // R5: the done flag holds until cleared
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !tx_done_clr |=> tx_done);
endmodule

// File: rtl/msp_rx.sv
module msp_rx
  import msp_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mode_nine,
  input  logic          rx_en,
  input  logic          filt_en,
  input  logic          rxd,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9
);
  localparam int OCW = $clog2(OVS);
  localparam int BCW = $clog2(DW + 2);
  localparam int S1  = OVS / 2 - 2;
  localparam int S2  = OVS / 2 - 1;
  localparam int S3  = OVS / 2;

  logic           rxd_m, rxd_s;
  rx_state_t      st;
  logic [OCW-1:0] ocnt;
  logic [BCW-1:0] bidx;
  logic [1:0]     smp;
  logic [DW-1:0]  shdat;
  logic           cap9;
  logic           bit_val, eval, done_evt, b9_fin, drop, load;
  logic [BCW-1:0] last_idx;

  assign bit_val  = vote3({smp, rxd_s});
  assign eval     = tick && (ocnt == OCW'(S3));
  assign last_idx = mode_nine ? BCW'(DW + 1) : BCW'(DW);
  assign done_evt = rx_en && (st == RX_BITS) && eval && (bidx == last_idx);
  assign b9_fin   = (bidx == BCW'(DW)) ? bit_val : cap9;
  assign drop     = mode_nine && filt_en && !b9_fin;
  assign load     = done_evt && !drop && (!rx_valid || rx_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      ocnt  <= '0;
      bidx  <= '0;
      smp   <= '0;
      shdat <= '0;
      cap9  <= 1'b0;
    end else if (!rx_en) begin
      st <= RX_IDLE;
    end else if (st == RX_IDLE) begin
      if (!rxd_s) begin
        st   <= RX_START;
        ocnt <= '0;
      end
    end else if (tick) begin
      ocnt <= (ocnt == OCW'(OVS - 1)) ? '0 : ocnt + OCW'(1);
      if (ocnt == OCW'(S1)) smp[1] <= rxd_s;
      if (ocnt == OCW'(S2)) smp[0] <= rxd_s;
      if (ocnt == OCW'(S3)) begin
        if (st == RX_START) begin
          if (bit_val) st <= RX_IDLE;
          else begin
            st   <= RX_BITS;
            bidx <= '0;
          end
        end else begin
          if (bidx < BCW'(DW))  shdat <= {bit_val, shdat[DW-1:1]};
          if (bidx == BCW'(DW)) cap9  <= bit_val;
          if (bidx == last_idx) st    <= RX_IDLE;
          else                  bidx  <= bidx + BCW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_bit9  <= 1'b0;
    end else if (load) begin
      rx_valid <= 1'b1;
      rx_data  <= shdat;
      rx_bit9  <= b9_fin;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  // R12: an unread buffer is never overwritten
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_bit9));
  // R9: a disabled receiver raises no flag
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !rx_valid |=> !rx_valid);
  // R8: a filtered data byte raises no flag
  p_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && drop && !rx_valid |=> !rx_valid);
endmodule

// File: rtl/mp_serial_port.sv
module mp_serial_port #(
  parameter int DW      = 8,
  parameter int OVS     = 16,
  parameter int FIX_DIV = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_nine,
  input  logic          rate_fixed,
  input  logic          smod,
  input  logic          ext_tick,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_bit9,
  output logic          tx_done,
  input  logic          tx_done_clr,
  output logic          txd,
  input  logic          rx_en,
  input  logic          filt_en,
  input  logic          rxd,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9
);
  logic tick;

  msp_baud #(.OVS(OVS), .FIX_DIV(FIX_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .rate_fixed(rate_fixed), .smod(smod),
    .ext_tick(ext_tick), .tick(tick)
  );

  msp_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_nine(mode_nine),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_bit9(tx_bit9), .tx_done(tx_done), .tx_done_clr(tx_done_clr), .txd(txd)
  );

  msp_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_nine(mode_nine),
    .rx_en(rx_en), .filt_en(filt_en), .rxd(rxd), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_bit9(rx_bit9)
  );
endmodule

// File: tb/mp_serial_port_test.sv
module mp_serial_port_test;
  localparam int EXT_DIV = 3;
  localparam int BIT_EXT = 16 * EXT_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_nine = 1'b0, rate_fixed = 1'b0, smod = 1'b0, ext_tick = 1'b0;
  logic tx_valid = 1'b0, tx_bit9 = 1'b0, tx_done_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic rx_en = 1'b0, filt_en = 1'b0, rx_ready = 1'b0;
  logic rxd_drv = 1'b1, loop = 1'b0;
  logic rxd;
  logic tx_ready, tx_done, txd, rx_valid, rx_bit9;
  logic [7:0] rx_data;
  int n_chk = 0, n_bad = 0;
  int tcnt = 0;

  assign rxd = loop ? txd : rxd_drv;

  mp_serial_port uut (
    .clk(clk), .rst_n(rst_n), .mode_nine(mode_nine), .rate_fixed(rate_fixed),
    .smod(smod), .ext_tick(ext_tick), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_bit9(tx_bit9), .tx_done(tx_done),
    .tx_done_clr(tx_done_clr), .txd(txd), .rx_en(rx_en), .filt_en(filt_en),
    .rxd(rxd), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_bit9(rx_bit9)
  );

  initial forever #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tcnt = (tcnt + 1) % EXT_DIV;
    ext_tick = (tcnt == 0);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_txd(input logic v);
    for (int i = 0; i < 5000 && txd !== v; i++) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 5000 && !tx_ready; i++) @(negedge clk);
  endtask

  task automatic offer(input logic [7:0] d, input logic b9);
    @(negedge clk);
    wait_ready();
    tx_data = d; tx_bit9 = b9; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic capture(input int bitclk, input int nb, output logic [10:0] got);
    got = '0;
    wait_txd(1'b0);
    repeat (bitclk / 2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < nb; i++) begin
      repeat (bitclk) @(negedge clk);
      got[i] = txd;
    end
  endtask

  // drives one frame on rxd; the last bit lasts stop_t ticks, gidx picks a glitched bit
  task automatic send_rx(input logic [7:0] d, input logic b9, input logic stopv,
                         input int stop_t, input int gidx);
    logic [9:0] seq;
    int nb;
    nb = mode_nine ? 10 : 9;
    seq = {stopv, (mode_nine ? b9 : stopv), d};
    repeat (BIT_EXT) begin @(negedge clk); rxd_drv = 1'b0; end
    for (int i = 0; i < nb; i++) begin
      for (int c = 0; c < ((i == nb - 1) ? stop_t * EXT_DIV : BIT_EXT); c++) begin
        @(negedge clk);
        rxd_drv = (i == gidx && (c == 23 || c == 24)) ? ~seq[i] : seq[i];
      end
    end
    @(negedge clk); rxd_drv = 1'b1;
    repeat (20 * EXT_DIV) @(negedge clk);
  endtask

  task automatic consume(input string tag);
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    chk(tag, rx_valid, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 txd idle", txd, 1'b1);
    chk("R1 tx_ready", tx_ready, 1'b1);
    chk("R1 tx_done", tx_done, 1'b0);
    chk("R1 rx_valid", rx_valid, 1'b0);
  endtask

  task automatic t_tx_short();
    logic [10:0] got;
    mode_nine = 1'b0;
    offer(8'hA3, 1'b0);
    chk("R2 ready low after accept", tx_ready, 1'b0);
    capture(BIT_EXT, 10, got);
    chk("R2 short frame bits", got[9:0], {1'b1, 8'hA3, 1'b0});
    wait_ready();
    chk("R5 done at frame end", tx_done, 1'b1);
    repeat (100) @(negedge clk);
    chk("R5 done sticky", tx_done, 1'b1);
    tx_done_clr = 1'b1; @(negedge clk); tx_done_clr = 1'b0;
    chk("R5 done cleared", tx_done, 1'b0);
  endtask

  task automatic t_tx_long(input logic b9);
    logic [10:0] got;
    mode_nine = 1'b1;
    offer(8'h5C, b9);
    capture(BIT_EXT, 11, got);
    chk("R3 long frame bits", got, {1'b1, b9, 8'h5C, 1'b0});
    wait_ready();
    tx_done_clr = 1'b1; @(negedge clk); tx_done_clr = 1'b0;
  endtask

  task automatic t_rate(input logic s, input int exp_w);
    int w;
    mode_nine = 1'b1; rate_fixed = 1'b1; smod = s; loop = 1'b1; rx_en = 1'b1;
    offer(8'h55, 1'b1);
    wait_txd(1'b0); wait_txd(1'b1); wait_txd(1'b0);
    w = 0;
    while (txd == 1'b0 && w < 5000) begin @(negedge clk); w++; end
    chk("R4 fixed bit width", w, exp_w);
    wait_ready();
    repeat (exp_w) @(negedge clk);
    chk("R4 loopback valid", rx_valid, 1'b1);
    chk("R4 loopback data", rx_data, 8'h55);
    consume("R4 loopback read");
    loop = 1'b0; rate_fixed = 1'b0; smod = 1'b0;
    tx_done_clr = 1'b1; @(negedge clk); tx_done_clr = 1'b0;
  endtask

  task automatic t_rx_short();
    mode_nine = 1'b0; rx_en = 1'b1;
    send_rx(8'h3E, 1'b0, 1'b1, 16, -1);
    chk("R6 valid", rx_valid, 1'b1);
    chk("R6 data", rx_data, 8'h3E);
    chk("R6 stop in bit9", rx_bit9, 1'b1);
    consume("R6 read clears");
    send_rx(8'hC4, 1'b0, 1'b0, 12, -1);
    chk("R6 low stop data", rx_data, 8'hC4);
    chk("R6 low stop in bit9", rx_bit9, 1'b0);
    consume("R6 read clears");
  endtask

  task automatic t_rx_long();
    mode_nine = 1'b1; filt_en = 1'b0;
    send_rx(8'hC1, 1'b0, 1'b0, 12, -1);
    chk("R7 valid with low stop", rx_valid, 1'b1);
    chk("R7 data", rx_data, 8'hC1);
    chk("R7 bit9 zero", rx_bit9, 1'b0);
    consume("R7 read");
    send_rx(8'h2B, 1'b1, 1'b1, 16, -1);
    chk("R7 data", rx_data, 8'h2B);
    chk("R7 bit9 one", rx_bit9, 1'b1);
    consume("R7 read");
  endtask

  task automatic t_filter();
    mode_nine = 1'b1; filt_en = 1'b1;
    send_rx(8'h12, 1'b0, 1'b1, 16, -1);
    chk("R8 data byte filtered", rx_valid, 1'b0);
    send_rx(8'h34, 1'b1, 1'b1, 16, -1);
    chk("R8 address byte flagged", rx_valid, 1'b1);
    chk("R8 address data", rx_data, 8'h34);
    chk("R8 address bit9", rx_bit9, 1'b1);
    consume("R8 read");
    filt_en = 1'b0;
  endtask

  task automatic t_rx_off();
    mode_nine = 1'b0; rx_en = 1'b0;
    send_rx(8'h77, 1'b0, 1'b1, 16, -1);
    chk("R9 disabled no flag", rx_valid, 1'b0);
    rx_en = 1'b1;
    send_rx(8'h66, 1'b0, 1'b1, 16, -1);
    chk("R9 enabled data", rx_data, 8'h66);
    consume("R9 read");
  endtask

  task automatic t_false_start();
    mode_nine = 1'b0;
    repeat (4 * EXT_DIV) begin @(negedge clk); rxd_drv = 1'b0; end
    @(negedge clk); rxd_drv = 1'b1;
    repeat (40 * EXT_DIV) @(negedge clk);
    chk("R10 false start no flag", rx_valid, 1'b0);
    send_rx(8'h9D, 1'b0, 1'b1, 16, -1);
    chk("R10 next frame data", rx_data, 8'h9D);
    consume("R10 read");
  endtask

  task automatic t_glitch();
    mode_nine = 1'b0;
    send_rx(8'hF0, 1'b0, 1'b1, 16, 3);
    chk("R11 glitch on zero bit", rx_data, 8'hF0);
    consume("R11 read");
    send_rx(8'hF0, 1'b0, 1'b1, 16, 5);
    chk("R11 glitch on one bit", rx_data, 8'hF0);
    consume("R11 read");
  endtask

  task automatic t_overrun();
    mode_nine = 1'b1; filt_en = 1'b0;
    send_rx(8'h11, 1'b1, 1'b1, 16, -1);
    send_rx(8'h22, 1'b0, 1'b1, 16, -1);
    chk("R12 still valid", rx_valid, 1'b1);
    chk("R12 old data kept", rx_data, 8'h11);
    chk("R12 old bit9 kept", rx_bit9, 1'b1);
    consume("R12 read");
    send_rx(8'h33, 1'b0, 1'b1, 16, -1);
    chk("R12 next frame data", rx_data, 8'h33);
    consume("R12 read");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_short();
    t_tx_long(1'b0);
    t_tx_long(1'b1);
    t_rate(1'b0, 64);
    t_rate(1'b1, 32);
    t_rx_short();
    t_rx_long();
    t_filter();
    t_rx_off();
    t_false_start();
    t_glitch();
    t_overrun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule